// File: doc/BRIEF.md
# Byte-Wide Bus Datapath Controller

This block is the register side of a small processor built around a single 8-bit shared bus. It holds a 16-bit program counter, a 16-bit memory address register, a memory data register and eight general registers named A, B, C, D, E, H, L and temp. Each cycle a 4-bit source code picks the one value that appears on the bus. Any number of load strobes can then capture that value into their destinations on the rising clock edge.

The two 16-bit registers meet the narrow bus one byte at a time. Each byte has its own load strobe, and the program counter has its own bus source code for each byte. A separate increment strobe advances the program counter. Registers A and temp drive the two ALU operand outputs directly. Memory read data and the ALU result come in as bus sources. The block exposes the bus value, the memory address and every register, so that memory, the ALU and the microcode sequencer can be attached around it.

Top module: `byteBusCore`

## Requirements
- R1: The bus shows the value selected by `srcSel`. Code 1 selects PC bits 7:0 and code 2 selects PC bits 15:8. Codes 3 to 10 select A, B, C, D, E, H, L and temp in that order. Code 11 selects `memIn` and code 12 selects `aluIn`.
- R2: Codes 0, 13, 14 and 15 select no driver, and the bus then reads 0x00.
- R3: The source code is decoded to exactly one active select line out of 16, so no two sources ever drive the bus together.
- R4: The `loadEn` bits are indexed as follows: 0 PC low byte, 1 PC high byte, 2 MAR low byte, 3 MAR high byte, 4 MDR, 5 to 12 A, B, C, D, E, H, L and temp. A set bit captures the bus value on the rising edge. Every register without a set bit keeps its value.
- R5: Loading one PC byte leaves the other PC byte unchanged.
- R6: `memAddr` is the MAR. Its low byte and its high byte are each written from the bus by their own strobe, in separate cycles or in the same cycle.
- R7: `pcInc` adds one to the PC and wraps from 0xFFFF to 0x0000. If either PC byte load strobe is set in the same cycle, that load takes effect and the increment is dropped.
- R8: `aluOpA` always equals A and `aluOpB` always equals temp, with no use of the bus.
- R9: `mdrOut` holds the byte last loaded into the MDR from the bus.
- R10: `rst` is synchronous and active high. It clears every register to zero, and it overrides any load or increment in the same cycle.
- R11: Several load strobes set in one cycle all capture the same bus value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous active-high clear |
| srcSel | input | 4 | Bus source code |
| loadEn | input | 13 | Destination load strobes |
| pcInc | input | 1 | Program counter increment strobe |
| memIn | input | 8 | Memory read data, bus source 11 |
| aluIn | input | 8 | ALU result, bus source 12 |
| busOut | output | 8 | Current bus value |
| pcOut | output | 16 | Program counter |
| memAddr | output | 16 | Memory address register |
| mdrOut | output | 8 | Memory data register |
| gpRegs | output | 64 | General registers; A in bits 7:0 up to temp in bits 63:56 |
| aluOpA | output | 8 | ALU operand from A |
| aluOpB | output | 8 | ALU operand from temp |

## Verification
The bench runs all 16 source codes against known register contents. A wrong decode would put a neighbouring register or a stale value onto the bus, or drive a non-zero value for an idle code. It pushes all 256 byte values through temp and compares the ALU operand output after each one, which exposes dropped or swapped bit lanes. It steps the PC across a low-byte carry and across the 0xFFFF wrap. A design that failed to carry between the bytes, or that let an increment win over a byte load, would show a wrong PC. Broadcast loads and a reset issued together with active strobes are also covered, which exposes a single-destination load path and a reset that loses to a load.

// File: rtl/byteBusPkg.sv
package byteBusPkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2 * DATA_W;
  localparam int NUM_GP  = 8;
  localparam int SEL_W   = 4;
  localparam int NUM_SRC = 1 << SEL_W;

  // bus source codes
  localparam int SRC_PC_LO = 1;
  localparam int SRC_PC_HI = 2;
  localparam int SRC_GP0   = 3;
  localparam int SRC_MEM   = SRC_GP0 + NUM_GP;
  localparam int SRC_ALU   = SRC_MEM + 1;

  // load strobe indices
  localparam int LD_PC_LO  = 0;
  localparam int LD_PC_HI  = 1;
  localparam int LD_MAR_LO = 2;
  localparam int LD_MAR_HI = 3;
  localparam int LD_MDR    = 4;
  localparam int LD_GP0    = 5;
  localparam int NUM_LD    = LD_GP0 + NUM_GP;

  typedef struct packed {
    logic [NUM_SRC-1:0] srcHot;
    logic [NUM_LD-1:0]  load;
    logic               pcStep;
    logic               clear;
  } strobes_t;
endpackage

// File: rtl/byteBusCtrl.sv
module byteBusCtrl
  import byteBusPkg::*;
(
  input  logic              rst,
  input  logic [SEL_W-1:0]  srcSel,
  input  logic [NUM_LD-1:0] loadEn,
  input  logic              pcInc,
  output strobes_t          strobes
);
  always_comb begin
    strobes        = '0;
    strobes.srcHot = NUM_SRC'(1) << srcSel;
    strobes.load   = loadEn;
    // a byte load of the PC takes precedence over counting
    strobes.pcStep = pcInc & ~loadEn[LD_PC_LO] & ~loadEn[LD_PC_HI];
    strobes.clear  = rst;
  end
endmodule

// File: rtl/byteBusDatapath.sv
module byteBusDatapath
  import byteBusPkg::*;
(
  input  logic                     clk,
  input  strobes_t                 strobes,
  input  logic [DATA_W-1:0]        memIn,
  input  logic [DATA_W-1:0]        aluIn,
  output logic [DATA_W-1:0]        busOut,
  output logic [ADDR_W-1:0]        pcOut,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [DATA_W-1:0]        mdrOut,
  output logic [NUM_GP*DATA_W-1:0] gpRegs
);
  logic [ADDR_W-1:0] pcReg;
  logic [ADDR_W-1:0] marReg;
  logic [DATA_W-1:0] mdrReg;
  logic [DATA_W-1:0] gpReg [NUM_GP];
  logic [DATA_W-1:0] srcData [NUM_SRC];
  logic [DATA_W-1:0] busVal;

  // candidate values per source code; unused codes stay zero
  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) srcData[s] = '0;
    srcData[SRC_PC_LO] = pcReg[DATA_W-1:0];
    srcData[SRC_PC_HI] = pcReg[ADDR_W-1:DATA_W];
    for (int g = 0; g < NUM_GP; g++) srcData[SRC_GP0+g] = gpReg[g];
    srcData[SRC_MEM] = memIn;
    srcData[SRC_ALU] = aluIn;
  end

  // AND-OR bus: one-hot select, code 0 contributes nothing
  always_comb begin
    busVal = '0;
    for (int s = 1; s < NUM_SRC; s++)
      busVal = busVal | (srcData[s] & {DATA_W{strobes.srcHot[s]}});
  end

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      pcReg <= '0;
    end else if (strobes.pcStep) begin
      pcReg <= pcReg + ADDR_W'(1);
    end else begin
      if (strobes.load[LD_PC_LO]) pcReg[DATA_W-1:0]      <= busVal;
      if (strobes.load[LD_PC_HI]) pcReg[ADDR_W-1:DATA_W] <= busVal;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      marReg <= '0;
      mdrReg <= '0;
    end else begin
      if (strobes.load[LD_MAR_LO]) marReg[DATA_W-1:0]      <= busVal;
      if (strobes.load[LD_MAR_HI]) marReg[ADDR_W-1:DATA_W] <= busVal;
      if (strobes.load[LD_MDR])    mdrReg                  <= busVal;
    end
  end

  for (genvar g = 0; g < NUM_GP; g++) begin : gen_gp
    always_ff @(posedge clk) begin
      if (strobes.clear)                gpReg[g] <= '0;
      else if (strobes.load[LD_GP0+g])  gpReg[g] <= busVal;
    end
    assign gpRegs[g*DATA_W +: DATA_W] = gpReg[g];
  end

  assign busOut  = busVal;
  assign pcOut   = pcReg;
  assign memAddr = marReg;
  assign mdrOut  = mdrReg;
endmodule

// File: rtl/byteBusCore.sv
module byteBusCore
  import byteBusPkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic [SEL_W-1:0]         srcSel,
  input  logic [NUM_LD-1:0]        loadEn,
  input  logic                     pcInc,
  input  logic [DATA_W-1:0]        memIn,
  input  logic [DATA_W-1:0]        aluIn,
  output logic [DATA_W-1:0]        busOut,
  output logic [ADDR_W-1:0]        pcOut,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [DATA_W-1:0]        mdrOut,
  output logic [NUM_GP*DATA_W-1:0] gpRegs,
  output logic [DATA_W-1:0]        aluOpA,
  output logic [DATA_W-1:0]        aluOpB
);
  strobes_t strobes;

  byteBusCtrl u_ctrl (
    .rst     (rst),
    .srcSel  (srcSel),
    .loadEn  (loadEn),
    .pcInc   (pcInc),
    .strobes (strobes)
  );

  byteBusDatapath u_dp (
    .clk     (clk),
    .strobes (strobes),
    .memIn   (memIn),
    .aluIn   (aluIn),
    .busOut  (busOut),
    .pcOut   (pcOut),
    .memAddr (memAddr),
    .mdrOut  (mdrOut),
    .gpRegs  (gpRegs)
  );

  // operand taps straight from A and temp
  assign aluOpA = gpRegs[DATA_W-1:0];
  assign aluOpB = gpRegs[NUM_GP*DATA_W-1 -: DATA_W];
endmodule

// File: rtl/byteBusCore_chk.sv
module byteBusCore_chk
  import byteBusPkg::*;
(
  input logic                     clk,
  input logic                     rst,
  input logic [SEL_W-1:0]         srcSel,
  input logic [NUM_LD-1:0]        loadEn,
  input logic                     pcInc,
  input logic [DATA_W-1:0]        busOut,
  input logic [ADDR_W-1:0]        pcOut,
  input logic [ADDR_W-1:0]        memAddr,
  input logic [DATA_W-1:0]        mdrOut,
  input logic [NUM_GP*DATA_W-1:0] gpRegs,
  input logic [DATA_W-1:0]        aluOpA,
  input logic [DATA_W-1:0]        aluOpB,
  input strobes_t                 strobes
);
  // R3
  one_driver_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(strobes.srcHot) == 1);

  // R2
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (srcSel == 0 || int'(srcSel) > SRC_ALU) |-> busOut == '0);

  // R7
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pcInc && !loadEn[LD_PC_LO] && !loadEn[LD_PC_HI])
      |=> pcOut == ADDR_W'($past(pcOut) + 1));

  // R5
  pc_lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (loadEn[LD_PC_LO] && !loadEn[LD_PC_HI])
      |=> (pcOut[ADDR_W-1:DATA_W] == $past(pcOut[ADDR_W-1:DATA_W]) &&
           pcOut[DATA_W-1:0] == $past(busOut)));

  // R6
  mar_hi_load_chk: assert property (@(posedge clk) disable iff (rst)
    loadEn[LD_MAR_HI] |=> memAddr[ADDR_W-1:DATA_W] == $past(busOut));

  // R4
  a_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !loadEn[LD_GP0] |=> gpRegs[DATA_W-1:0] == $past(gpRegs[DATA_W-1:0]));

  // R8
  operand_tap_chk: assert property (@(posedge clk) disable iff (rst)
    aluOpA == gpRegs[DATA_W-1:0] && aluOpB == gpRegs[NUM_GP*DATA_W-1 -: DATA_W]);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pcOut == '0 && memAddr == '0 && mdrOut == '0 && gpRegs == '0));
endmodule

bind byteBusCore byteBusCore_chk u_chk (.*);

// File: tb/byteBusCore_tb.sv
`timescale 1ns/1ps
module byteBusCore_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  srcSel = '0;
  logic [12:0] loadEn = '0;
  logic        pcInc = 1'b0;
  logic [7:0]  memIn = '0;
  logic [7:0]  aluIn = '0;
  logic [7:0]  busOut, mdrOut, aluOpA, aluOpB;
  logic [15:0] pcOut, memAddr;
  logic [63:0] gpRegs;

  int checks = 0;
  int errors = 0;

  logic [7:0]  mGp [8];
  logic [15:0] mPc, mMar;
  logic [7:0]  mMdr;

  always #2.5 clk = ~clk;

  byteBusCore u_dut (
    .clk(clk), .rst(rst), .srcSel(srcSel), .loadEn(loadEn), .pcInc(pcInc),
    .memIn(memIn), .aluIn(aluIn), .busOut(busOut), .pcOut(pcOut),
    .memAddr(memAddr), .mdrOut(mdrOut), .gpRegs(gpRegs),
    .aluOpA(aluOpA), .aluOpB(aluOpB)
  );

  function automatic logic [7:0] expBus(input logic [3:0] s);
    case (s)
      4'd1:  return mPc[7:0];
      4'd2:  return mPc[15:8];
      4'd11: return memIn;
      4'd12: return aluIn;
      default: return (s >= 4'd3 && s <= 4'd10) ? mGp[s-3] : 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkState(input string req);
    check({req, " R5 R7 pc"}, 64'(pcOut), 64'(mPc));
    check({req, " R6 mar"}, 64'(memAddr), 64'(mMar));
    check({req, " R9 mdr"}, 64'(mdrOut), 64'(mMdr));
    for (int g = 0; g < 8; g++)
      check({req, " R4 gp"}, 64'(gpRegs[g*8 +: 8]), 64'(mGp[g]));
    check({req, " R8 opA"}, 64'(aluOpA), 64'(mGp[0]));
    check({req, " R8 opB"}, 64'(aluOpB), 64'(mGp[7]));
  endtask

  task automatic cycle(input logic [3:0] s, input logic [12:0] ld, input logic inc, input string req);
    logic [7:0] b;
    srcSel = s; loadEn = ld; pcInc = inc;
    #1;
    b = expBus(s);
    check({req, " R1 R2 R3 bus"}, 64'(busOut), 64'(b));
    if (rst) begin
      mPc = '0; mMar = '0; mMdr = '0;
      for (int g = 0; g < 8; g++) mGp[g] = '0;
    end else begin
      if (inc && !ld[0] && !ld[1]) mPc = mPc + 16'd1;
      else begin
        if (ld[0]) mPc[7:0]  = b;
        if (ld[1]) mPc[15:8] = b;
      end
      if (ld[2]) mMar[7:0]  = b;
      if (ld[3]) mMar[15:8] = b;
      if (ld[4]) mMdr = b;
      for (int g = 0; g < 8; g++) if (ld[5+g]) mGp[g] = b;
    end
    @(posedge clk); #1;
    srcSel = '0; loadEn = '0; pcInc = 1'b0;
    checkState(req);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mPc = '0; mMar = '0; mMdr = '0;
    for (int g = 0; g < 8; g++) mGp[g] = '0;
    @(posedge clk); #1;
    rst = 1'b1;
    cycle(4'd11, 13'h1FFF, 1'b1, "R10 reset");
    rst = 1'b0;

    // fill every general register through the bus
    for (int i = 0; i < 8; i++) begin
      memIn = 8'(8'h3C + 8'(29 * i));
      cycle(4'd11, 13'(1) << (5 + i), 1'b0, "R4 gp load");
    end

    // every source code
    memIn = 8'h5A; aluIn = 8'hC3;
    for (int s = 0; s < 16; s++) cycle(4'(s), '0, 1'b0, "R1 R2 sweep");

    // all byte values through temp to the operand tap
    for (int v = 0; v < 256; v++) begin
      memIn = 8'(v);
      cycle(4'd11, 13'h1000, 1'b0, "R8 temp sweep");
    end

    cycle(4'd3, 13'h0010, 1'b0, "R9 mdr from A");
    cycle(4'd4, 13'h0004, 1'b0, "R6 mar low");
    cycle(4'd5, 13'h0008, 1'b0, "R6 mar high");
    memIn = 8'hE1;
    cycle(4'd11, 13'h000C, 1'b0, "R6 mar both");

    memIn = 8'h34; cycle(4'd11, 13'h0001, 1'b0, "R5 pc low");
    memIn = 8'h12; cycle(4'd11, 13'h0002, 1'b0, "R5 pc high");
    cycle(4'd1, '0, 1'b0, "R1 pc low src");
    cycle(4'd2, '0, 1'b0, "R1 pc high src");

    for (int k = 0; k < 300; k++) cycle(4'd0, '0, 1'b1, "R7 count");

    memIn = 8'hFE; cycle(4'd11, 13'h0001, 1'b0, "R5 pc low");
    memIn = 8'hFF; cycle(4'd11, 13'h0002, 1'b0, "R5 pc high");
    for (int k = 0; k < 3; k++) cycle(4'd0, '0, 1'b1, "R7 wrap");

    memIn = 8'h77; cycle(4'd11, 13'h0001, 1'b1, "R7 load beats inc");
    memIn = 8'h88; cycle(4'd11, 13'h0002, 1'b1, "R7 load beats inc");

    aluIn = 8'h9E;
    cycle(4'd12, 13'h00D8, 1'b0, "R11 broadcast");

    rst = 1'b1;
    cycle(4'd12, 13'h1FFF, 1'b1, "R10 reset over load");
    rst = 1'b0;
    cycle(4'd0, '0, 1'b0, "R10 after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule